// File: doc/BRIEF.md
# Battery Charge Sequencing Controller

This block steps a single-cell battery through its charge cycle using digitized comparator flags. The flags are enable, deep shutdown, input headroom, battery presence, and two battery-level flags. A battery under the low level receives only a DC precharge current, with the switching stage held off. Once the battery is above the low level, the switcher runs at the reduced (10%) current setting and the DC source stays on. Above the trickle level, the switcher moves to full-scale current and the DC source turns off. Phase changes take effect one clock after the flags change.

A trickle timer counts clock cycles spent in the trickle phase and clears whenever that phase is left. If trickle lasts the full limit, the controller stops charging and latches a bad-battery fault. The latch is cleared by removing the battery or by deep shutdown. When a battery is present again, a fresh cycle starts. A low enable flag or a lost input headroom flag puts the block into a disabled state. In that state both status outputs are low and the feedback-ground control is released. Deep shutdown overrides every other flag.

Top module: `charge_sequencer`

## Requirements
- R1: After reset, and one cycle after `en_ok` goes low, the block is disabled. In the disabled state all drive and status outputs are 0 and `fbg_drive` is 0 (released). It stays disabled while `en_ok` is low.
- R2: When enabled with a battery present and `bat_above_low`=0, the outputs are `pre_en`=1, `sw_en`=0, `full_sel`=0 and `stat_chg`=1 from the next cycle.
- R3: With `bat_above_low`=1 and `bat_above_trkl`=0, the trickle phase gives `pre_en`=1, `sw_en`=1, `full_sel`=0 and `stat_chg`=1.
- R4: With both battery-level flags 1, the full-scale phase gives `pre_en`=0, `sw_en`=1, `full_sel`=1 and `stat_chg`=1.
- R5: If the trickle phase lasts TRKL_CYCLES consecutive cycles, the next cycle enters the fault state. In that state `stat_flt`=1, `stat_chg`=0 and all drives are 0, while `fbg_drive` stays 1.
- R6: A latched fault holds while the battery stays present, whatever the level flags do. This includes a disable and re-enable, which shows the fault again. After `bat_present` is 0 for a cycle and then returns to 1, a new cycle starts from the phase the level flags select.
- R7: `duv_ok`=0 disables the block, as in R1. When the flag recovers, the phase selected by the flags resumes.
- R8: `deep_sd`=1 overrides all other flags and disables the block. It also clears the fault latch, so after release a fresh cycle starts.
- R9: The trickle timer clears whenever the trickle phase is left. On re-entry the phase again gets the full TRKL_CYCLES before a fault.
- R10: When enabled with `bat_present`=0, all drive and status outputs are 0 and `fbg_drive`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_ok | input | 1 | Enable flag |
| deep_sd | input | 1 | Deep shutdown flag, highest priority |
| duv_ok | input | 1 | Input-minus-battery headroom is adequate |
| bat_present | input | 1 | Battery detected |
| bat_above_low | input | 1 | Battery above the low-battery level |
| bat_above_trkl | input | 1 | Battery above the trickle level |
| pre_en | output | 1 | DC precharge source enable |
| sw_en | output | 1 | Switching stage enable |
| full_sel | output | 1 | 1 = full-scale current, 0 = trickle (10%) |
| stat_chg | output | 1 | Charging status |
| stat_flt | output | 1 | Bad-battery fault status |
| fbg_drive | output | 1 | 1 = feedback ground driven, 0 = released |

## Verification
The assertions assume the flags are synchronous to `clk` and stable around each edge. They also assume the trickle level implies the low level, so `bat_above_trkl` is never 1 while `bat_above_low` is 0. The stimulus changes flags only just after an edge and always keeps that ordering. Removal is modelled by dropping `bat_present` for at least one full cycle. The bench uses a short trickle limit so that the fault path and the timer-restart path are reached within the run.

// File: rtl/chg_seq_pkg.sv
package chg_seq_pkg;

  typedef enum logic [2:0] {
    ST_OFF   = 3'd0,
    ST_WAIT  = 3'd1,
    ST_PRE   = 3'd2,
    ST_TRK   = 3'd3,
    ST_FULL  = 3'd4,
    ST_FAULT = 3'd5
  } phase_t;

  typedef struct packed {
    logic pre_en;
    logic sw_en;
    logic full_sel;
    logic stat_chg;
    logic stat_flt;
    logic fbg_drive;
  } drive_t;

endpackage

// File: rtl/chg_trickle_timer.sv
module chg_trickle_timer #(
  parameter int unsigned LIMIT = 1000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expire
);
  localparam int unsigned CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (!run)       cnt <= '0;
    else if (cnt != LAST) cnt <= cnt + 1'b1;
  end

  assign expire = run && (cnt == LAST);

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST); // R9
  AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> cnt == '0); // R9

endmodule

// File: rtl/chg_phase_fsm.sv
module chg_phase_fsm
  import chg_seq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   en_ok,
  input  logic   deep_sd,
  input  logic   duv_ok,
  input  logic   bat_present,
  input  logic   bat_above_low,
  input  logic   bat_above_trkl,
  input  logic   expire,
  output phase_t phase,
  output logic   in_trickle
);
  phase_t nxt;
  logic   fault_q;
  logic   fault_d;

  always_comb begin
    nxt = ST_OFF;
    if (deep_sd || !en_ok || !duv_ok) nxt = ST_OFF;
    else if (!bat_present)            nxt = ST_WAIT;
    else if (fault_q)                 nxt = ST_FAULT;
    else if (!bat_above_low)          nxt = ST_PRE;
    else if (!bat_above_trkl)         nxt = (phase == ST_TRK && expire) ? ST_FAULT : ST_TRK;
    else                              nxt = ST_FULL;
  end

  always_comb begin
    fault_d = fault_q;
    if (deep_sd || !bat_present)                      fault_d = 1'b0;
    else if (phase == ST_TRK && nxt == ST_FAULT)      fault_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= ST_OFF;
      fault_q <= 1'b0;
    end else begin
      phase   <= nxt;
      fault_q <= fault_d;
    end
  end

  assign in_trickle = (phase == ST_TRK);

  AST_SD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    deep_sd |=> (phase == ST_OFF) && !fault_q); // R8
  AST_EN_LOW_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !en_ok |=> phase == ST_OFF); // R1
  AST_DUV_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !duv_ok |=> phase == ST_OFF); // R7
  AST_FAULT_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    phase == ST_FAULT |-> fault_q); // R5
  AST_REMOVE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !bat_present |=> !fault_q); // R6

endmodule

// File: rtl/chg_out_decode.sv
module chg_out_decode
  import chg_seq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  phase_t phase,
  output drive_t drv
);
  always_comb begin
    drv = '0;
    unique case (phase)
      ST_OFF:   drv = '0;
      ST_WAIT:  drv.fbg_drive = 1'b1;
      ST_PRE:   begin drv.pre_en = 1'b1; drv.stat_chg = 1'b1; drv.fbg_drive = 1'b1; end
      ST_TRK:   begin drv.pre_en = 1'b1; drv.sw_en = 1'b1; drv.stat_chg = 1'b1; drv.fbg_drive = 1'b1; end
      ST_FULL:  begin drv.sw_en = 1'b1; drv.full_sel = 1'b1; drv.stat_chg = 1'b1; drv.fbg_drive = 1'b1; end
      ST_FAULT: begin drv.stat_flt = 1'b1; drv.fbg_drive = 1'b1; end
      default:  drv = '0;
    endcase
  end

  AST_FULL_NO_PRE: assert property (@(posedge clk) disable iff (!rst_n)
    drv.full_sel |-> !drv.pre_en && drv.sw_en); // R4
  AST_STATUS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(drv.stat_chg && drv.stat_flt)); // R5
  AST_RELEASED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !drv.fbg_drive |-> !drv.stat_chg && !drv.stat_flt && !drv.sw_en && !drv.pre_en); // R1

endmodule

// File: rtl/charge_sequencer.sv
module charge_sequencer
  import chg_seq_pkg::*;
#(
  parameter int unsigned TRKL_CYCLES = 1000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_ok,
  input  logic deep_sd,
  input  logic duv_ok,
  input  logic bat_present,
  input  logic bat_above_low,
  input  logic bat_above_trkl,
  output logic pre_en,
  output logic sw_en,
  output logic full_sel,
  output logic stat_chg,
  output logic stat_flt,
  output logic fbg_drive
);
  phase_t phase;
  logic   in_trickle;
  logic   expire;
  drive_t drv;

  chg_trickle_timer #(.LIMIT(TRKL_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(in_trickle), .expire(expire)
  );

  chg_phase_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .en_ok(en_ok), .deep_sd(deep_sd), .duv_ok(duv_ok),
    .bat_present(bat_present), .bat_above_low(bat_above_low),
    .bat_above_trkl(bat_above_trkl), .expire(expire),
    .phase(phase), .in_trickle(in_trickle)
  );

  chg_out_decode u_dec (
    .clk(clk), .rst_n(rst_n), .phase(phase), .drv(drv)
  );

  assign pre_en    = drv.pre_en;
  assign sw_en     = drv.sw_en;
  assign full_sel  = drv.full_sel;
  assign stat_chg  = drv.stat_chg;
  assign stat_flt  = drv.stat_flt;
  assign fbg_drive = drv.fbg_drive;

  AST_PRE_NO_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_en && !sw_en) |-> !full_sel && stat_chg); // R2
  AST_TRK_MIX: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_en && sw_en) |-> !full_sel); // R3
  AST_NO_BAT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (en_ok && duv_ok && !deep_sd && !bat_present) |=> !stat_chg && !stat_flt && fbg_drive); // R10

endmodule

// File: tb/charge_sequencer_test.sv
module charge_sequencer_test;
  localparam int unsigned LIM = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en_ok = 1'b0, deep_sd = 1'b0, duv_ok = 1'b1;
  logic bat_present = 1'b0, bat_above_low = 1'b0, bat_above_trkl = 1'b0;
  logic pre_en, sw_en, full_sel, stat_chg, stat_flt, fbg_drive;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // expected vectors: {pre, sw, full, chg, flt, fbg}
  localparam logic [5:0] E_OFF   = 6'b000000;
  localparam logic [5:0] E_WAIT  = 6'b000001;
  localparam logic [5:0] E_PRE   = 6'b100101;
  localparam logic [5:0] E_TRK   = 6'b110101;
  localparam logic [5:0] E_FULL  = 6'b011101;
  localparam logic [5:0] E_FAULT = 6'b000011;

  always #5 clk = ~clk;

  charge_sequencer #(.TRKL_CYCLES(LIM)) uut (
    .clk(clk), .rst_n(rst_n), .en_ok(en_ok), .deep_sd(deep_sd), .duv_ok(duv_ok),
    .bat_present(bat_present), .bat_above_low(bat_above_low),
    .bat_above_trkl(bat_above_trkl), .pre_en(pre_en), .sw_en(sw_en),
    .full_sel(full_sel), .stat_chg(stat_chg), .stat_flt(stat_flt), .fbg_drive(fbg_drive)
  );

  task automatic check(input string req, input logic [5:0] exp);
    logic [5:0] act;
    act = {pre_en, sw_en, full_sel, stat_chg, stat_flt, fbg_drive};
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: outputs %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  task automatic flags(input logic en, input logic sd, input logic duv,
                       input logic bp, input logic lo, input logic tk);
    en_ok = en; deep_sd = sd; duv_ok = duv;
    bat_present = bp; bat_above_low = lo; bat_above_trkl = tk;
  endtask

  task automatic t_reset;
    check("R1", E_OFF);
    flags(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
    step(3);
    check("R1", E_OFF);
  endtask

  task automatic t_phases;
    flags(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    step(1); check("R10", E_WAIT);
    bat_present = 1'b1;
    step(1); check("R2", E_PRE);
    bat_above_low = 1'b1;
    step(1); check("R3", E_TRK);
    bat_above_trkl = 1'b1;
    step(1); check("R4", E_FULL);
    en_ok = 1'b0;
    step(1); check("R1", E_OFF);
    en_ok = 1'b1;
    step(1); check("R4", E_FULL);
  endtask

  task automatic t_duv;
    duv_ok = 1'b0;
    step(1); check("R7", E_OFF);
    step(2); check("R7", E_OFF);
    duv_ok = 1'b1;
    step(1); check("R7", E_FULL);
  endtask

  task automatic t_timeout;
    flags(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
    step(1); check("R3", E_TRK);
    step(LIM - 1); check("R5", E_TRK);
    step(1); check("R5", E_FAULT);
    bat_above_trkl = 1'b1;
    step(2); check("R6", E_FAULT);
    en_ok = 1'b0;
    step(1); check("R6", E_OFF);
    en_ok = 1'b1;
    step(1); check("R6", E_FAULT);
    bat_present = 1'b0;
    step(1); check("R6", E_WAIT);
    bat_present = 1'b1;
    step(1); check("R6", E_FULL);
  endtask

  task automatic t_restart_timer;
    flags(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
    step(10); check("R9", E_TRK);
    bat_above_trkl = 1'b1;
    step(1); check("R9", E_FULL);
    bat_above_trkl = 1'b0;
    step(1); check("R9", E_TRK);
    step(LIM - 1); check("R9", E_TRK);
    step(1); check("R9", E_FAULT);
  endtask

  task automatic t_deep_sd;
    deep_sd = 1'b1;
    step(1); check("R8", E_OFF);
    bat_above_low = 1'b0;
    step(1); check("R8", E_OFF);
    deep_sd = 1'b0;
    step(1); check("R8", E_PRE);
    deep_sd = 1'b1; en_ok = 1'b1;
    step(1); check("R8", E_OFF);
    deep_sd = 1'b0;
  endtask

  initial begin
    step(2);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_phases();
    t_duv();
    t_timeout();
    t_restart_timer();
    t_deep_sd();
    done = 1'b1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: done 0 expected 1");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule